// File: doc/BRIEF.md
# Dual-granularity watchdog timer

This block is a 16-bit watchdog counter that software runs through a small byte-wide register bank. One configuration bit picks the count unit: seconds or minutes. In seconds mode the counter moves once per pulse of a one-pulse-per-second tick. In minutes mode an internal prescaler divides that tick by 60.

Software arms or refreshes the watchdog by writing a nonzero count and stops it by writing zero. The count is written in two bytes: the high byte first, then the low byte. The write to the low byte commits both bytes together.

When the count reaches zero the counter stops and a sticky expiry flag is set. If enabled, one or more reset outputs then pulse for a fixed number of clocks. The outputs are a keyboard-path reset, a power-good-path reset and a timeout output, and configuration bits choose which of them fire. With every one of those bits clear, the block still counts and flags expiry but asserts nothing, which is a test mode.

Top module: `wdg_dual_unit`

## Requirements
- R1: After reset, every register reads 0x00, the counter is stopped, and every reset and status output is low.
- R2: Register addresses: 0x71 is control (bit 0 is the expiry flag, other bits read 0), 0x72 is configuration (reads back as written), 0x73 and 0x74 read the low and high bytes of the remaining count.
- R3: A write to 0x74 only holds the high byte. A later write to 0x73 loads the count as {held high byte, written low byte} in one step, and the count read back before that low write is unchanged.
- R4: With configuration bit 7 set (seconds unit), a running count drops by one on each clock in which sec_tick is high.
- R5: With configuration bit 7 clear (minutes unit), a running count drops by one on every 60th sec_tick. Every load through 0x73 clears the prescaler.
- R6: Writing a count of zero through 0x73 stops the counter and clears the count. Later sec_tick pulses then change nothing and set no flag.
- R7: When a running count goes from 1 to 0, control bit 0 is set and running_o falls. The counter stays at zero, whatever ticks arrive, until software loads a new nonzero value.
- R8: Writing 0x71 with bit 0 set clears the expiry flag. Writing it with bit 0 clear leaves the flag as it is.
- R9: From the clock after expiry, each reset output is high for exactly RST_CLKS clocks (8 by default): kbd_rst_o if configuration bit 6 and kbd_rst_en were both set, pwr_rst_o if bit 4 was set, tmo_o if bit 5 was set.
- R10: With configuration bits 6, 5 and 4 all clear, expiry still sets the flag but no reset output ever rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| sec_tick | input | 1 | One-clock pulse per second |
| kbd_rst_en | input | 1 | Allows the keyboard-path reset |
| kbd_rst_o | output | 1 | Keyboard-path reset pulse |
| pwr_rst_o | output | 1 | Power-good-path reset pulse |
| tmo_o | output | 1 | Timeout output pulse |
| expired_o | output | 1 | Sticky expiry flag |
| running_o | output | 1 | Counter is counting |

## Verification
The case that is hardest to reach from the ports is the minutes unit, where the prescaler state is invisible. A reload must restart the 60-tick division without leaving a partial count behind. The bench loads a count, sends 30 ticks, and loads again. It then shows that 59 further ticks leave the count unchanged and the 60th tick decrements it. Expiry-time reset selection is checked by counting the high clocks of each output over a window longer than the pulse, for each of the configuration patterns.

// File: rtl/wdg_pkg.sv
// Package: shared addresses, configuration bit positions and widths for the
// dual-granularity watchdog. Assumes byte-wide register access.
package wdg_pkg;
    localparam int          CNT_W     = 16;
    localparam logic [7:0]  A_CTRL    = 8'h71;
    localparam logic [7:0]  A_CFG     = 8'h72;
    localparam logic [7:0]  A_CNT_LO  = 8'h73;
    localparam logic [7:0]  A_CNT_HI  = 8'h74;
    localparam int          B_SECONDS = 7;
    localparam int          B_KBD     = 6;
    localparam int          B_TMO     = 5;
    localparam int          B_PWR     = 4;
    localparam int          B_FLAG    = 0;
    localparam int          TICKS_PER_MIN = 60;

    typedef struct packed {
        logic kbd;
        logic tmo;
        logic pwr;
    } rst_sel_t;
endpackage

// File: rtl/wdg_regs.sv
// Module: register bank. Decodes byte writes, holds configuration, the held
// high byte and the sticky expiry flag, and issues a load on low-byte writes.
// Assumes the count it reads back is supplied by the counter.
module wdg_regs
    import wdg_pkg::*;
#(
    parameter bit WIDE = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [7:0]       addr,
    input  logic [7:0]       wdata,
    input  logic [CNT_W-1:0] count,
    input  logic             expire,
    output logic [7:0]       rdata,
    output logic [7:0]       cfg,
    output logic             flag,
    output logic             load,
    output logic [CNT_W-1:0] load_val
);
    logic [7:0] hi_hold;

    // Configuration register and held high byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg     <= '0;
            hi_hold <= '0;
        end else if (we) begin
            if (addr == A_CFG)    cfg     <= wdata;
            if (addr == A_CNT_HI) hi_hold <= wdata;
        end
    end

    // Sticky expiry flag: set by expiry, cleared by write-one; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (expire)
            flag <= 1'b1;
        else if (we && addr == A_CTRL && wdata[B_FLAG])
            flag <= 1'b0;
    end

    // Load request and committed value on a low-byte write.
    always_comb begin
        load = we && (addr == A_CNT_LO);
        if (WIDE) load_val = {hi_hold, wdata};
        else      load_val = {8'h00, wdata};
    end

    // Read multiplexer.
    always_comb begin
        unique case (addr)
            A_CTRL:   rdata = {7'b0, flag};
            A_CFG:    rdata = cfg;
            A_CNT_LO: rdata = count[7:0];
            A_CNT_HI: rdata = count[15:8];
            default:  rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/wdg_timebase.sv
// Module: unit timebase. Passes the seconds tick through in seconds mode or
// divides it by a parameterised count in minutes mode. The prescaler clears
// on every load and holds while the counter is stopped.
module wdg_timebase #(
    parameter int DIV = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sec_tick,
    input  logic seconds,
    input  logic running,
    input  logic clear,
    output logic unit_tick
);
    localparam int PW = $clog2(DIV);
    logic [PW-1:0] pre;
    logic          wrap;

    assign wrap = (pre == PW'(DIV - 1));

    // Unit strobe selection.
    always_comb begin
        if (seconds) unit_tick = sec_tick && running;
        else         unit_tick = sec_tick && running && wrap;
    end

    // Prescaler counting seconds within a minute.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            pre <= '0;
        else if (running && sec_tick && !seconds)
            pre <= wrap ? '0 : pre + 1'b1;
    end
endmodule

// File: rtl/wdg_counter.sv
// Module: down-counter. Loads on request (zero stops), decrements on each
// unit strobe, and reports expiry on the 1-to-0 step. Assumes a load and a
// strobe in the same cycle resolve in favour of the load.
module wdg_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         unit_tick,
    output logic [W-1:0] count,
    output logic         running,
    output logic         expire
);
    assign expire = running && unit_tick && !load && (count == W'(1));

    // Count and run state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count   <= '0;
            running <= 1'b0;
        end else if (load) begin
            count   <= load_val;
            running <= (load_val != '0);
        end else if (running && unit_tick) begin
            count   <= count - 1'b1;
            if (count == W'(1)) running <= 1'b0;
        end
    end
endmodule

// File: rtl/wdg_pulse.sv
// Module: reset pulse generator. Captures the enabled reset targets at expiry
// and drives them for RST_CLKS clocks from the following clock.
module wdg_pulse
    import wdg_pkg::*;
#(
    parameter int RST_CLKS = 8
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     expire,
    input  rst_sel_t sel,
    output rst_sel_t outs
);
    localparam int PW = $clog2(RST_CLKS + 1);
    logic [PW-1:0] left;
    rst_sel_t      armed;

    // Pulse length counter and captured targets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left  <= '0;
            armed <= '0;
        end else if (expire) begin
            left  <= (sel != '0) ? PW'(RST_CLKS) : '0;
            armed <= sel;
        end else if (left != '0) begin
            left  <= left - 1'b1;
        end
    end

    // Output gating.
    always_comb begin
        outs = (left != '0) ? armed : '0;
    end
endmodule

// File: rtl/wdg_dual_unit.sv
// Module: dual-granularity watchdog top. Connects the register bank,
// timebase, down-counter and reset pulse generator.
module wdg_dual_unit
    import wdg_pkg::*;
#(
    parameter bit WIDE     = 1'b1,
    parameter int RST_CLKS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_we,
    input  logic [7:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       sec_tick,
    input  logic       kbd_rst_en,
    output logic       kbd_rst_o,
    output logic       pwr_rst_o,
    output logic       tmo_o,
    output logic       expired_o,
    output logic       running_o
);
    logic [CNT_W-1:0] count_q, load_val;
    logic [7:0]       cfg_q;
    logic             flag_q, load, expire, running_q, unit_tick;
    rst_sel_t         sel, outs;

    wdg_regs #(.WIDE(WIDE)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .count(count_q), .expire(expire),
        .rdata(reg_rdata), .cfg(cfg_q), .flag(flag_q),
        .load(load), .load_val(load_val)
    );

    wdg_timebase #(.DIV(TICKS_PER_MIN)) u_tb (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
        .seconds(cfg_q[B_SECONDS]), .running(running_q), .clear(load),
        .unit_tick(unit_tick)
    );

    wdg_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val),
        .unit_tick(unit_tick), .count(count_q), .running(running_q),
        .expire(expire)
    );

    // Reset target selection from configuration and the keyboard enable.
    always_comb begin
        sel.kbd = cfg_q[B_KBD] && kbd_rst_en;
        sel.tmo = cfg_q[B_TMO];
        sel.pwr = cfg_q[B_PWR];
    end

    wdg_pulse #(.RST_CLKS(RST_CLKS)) u_pulse (
        .clk(clk), .rst_n(rst_n), .expire(expire), .sel(sel), .outs(outs)
    );

    assign kbd_rst_o = outs.kbd;
    assign pwr_rst_o = outs.pwr;
    assign tmo_o     = outs.tmo;
    assign expired_o = flag_q;
    assign running_o = running_q;
endmodule

// File: rtl/wdg_dual_unit_chk.sv
// Checker: temporal properties of the watchdog, bound to the top module.
module wdg_dual_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_we,
    input logic [7:0]  reg_addr,
    input logic [7:0]  reg_wdata,
    input logic        sec_tick,
    input logic        pwr_rst_o,
    input logic        tmo_o,
    input logic        expired_o,
    input logic        running_o,
    input logic [15:0] count_q,
    input logic [7:0]  cfg_q
);
    logic wr_lo;
    assign wr_lo = reg_we && reg_addr == 8'h73;

    assert_stop_on_expiry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(expired_o) |-> (!running_o && count_q == 16'h0));

    assert_idle_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!running_o && !wr_lo) |=> $stable(count_q));

    assert_sec_decrement_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (running_o && cfg_q[7] && sec_tick && !reg_we && count_q > 16'h1)
        |=> count_q == $past(count_q) - 16'h1);

    assert_pwr_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_rst_o) |-> $past(cfg_q[4]));

    assert_tmo_target_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmo_o) |-> $past(cfg_q[5]));

    assert_load_sets_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && reg_wdata != 8'h0) |=> running_o);
endmodule

bind wdg_dual_unit wdg_dual_unit_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .sec_tick(sec_tick), .pwr_rst_o(pwr_rst_o),
    .tmo_o(tmo_o), .expired_o(expired_o), .running_o(running_o),
    .count_q(count_q), .cfg_q(cfg_q)
);

// File: tb/test_wdg_dual_unit.sv
module test_wdg_dual_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       sec_tick = 1'b0;
    logic       kbd_rst_en = 1'b1;
    logic       kbd_rst_o, pwr_rst_o, tmo_o, expired_o, running_o;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    localparam int PULSE = 8;

    always #10 clk = ~clk;

    wdg_dual_unit i_wdg_dual_unit (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sec_tick(sec_tick),
        .kbd_rst_en(kbd_rst_en), .kbd_rst_o(kbd_rst_o), .pwr_rst_o(pwr_rst_o),
        .tmo_o(tmo_o), .expired_o(expired_o), .running_o(running_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            sec_tick = 1'b1;
            @(negedge clk);
            sec_tick = 1'b0;
        end
    endtask

    function automatic int cnt_now();
        return 0;
    endfunction

    task automatic rd_count(output int c);
        logic [7:0] lo, hi;
        rd(8'h73, lo);
        rd(8'h74, hi);
        c = {hi, lo};
    endtask

    // Count high clocks of each reset output over a window after expiry.
    task automatic pulse_counts(output int k, output int p, output int t);
        k = 0; p = 0; t = 0;
        for (int i = 0; i < 3 * PULSE; i++) begin
            k += kbd_rst_o; p += pwr_rst_o; t += tmo_o;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd(8'h71, d); check("R1 ctrl", d, 0);
        rd(8'h72, d); check("R1 cfg", d, 0);
        rd(8'h73, d); check("R1 lo", d, 0);
        rd(8'h74, d); check("R1 hi", d, 0);
        check("R1 outputs", {kbd_rst_o, pwr_rst_o, tmo_o, expired_o, running_o}, 0);
    endtask

    task automatic t_seconds_expiry();
        int c, k, p, t;
        logic [7:0] d;
        wr(8'h72, 8'hC0);
        rd(8'h72, d); check("R2 cfg readback", d, 8'hC0);
        wr(8'h74, 8'h00); wr(8'h73, 8'h03);
        ticks(2);
        rd_count(c); check("R4 seconds decrement", c, 1);
        ticks(1);
        pulse_counts(k, p, t);
        check("R9 kbd pulse length", k, PULSE);
        check("R9 pwr not selected", p, 0);
        check("R9 tmo not selected", t, 0);
        rd(8'h71, d); check("R7 flag set", d, 1);
        check("R7 running low", running_o, 0);
        ticks(3);
        rd_count(c); check("R7 stays stopped", c, 0);
        wr(8'h71, 8'h00);
        rd(8'h71, d); check("R8 write zero keeps flag", d, 1);
        wr(8'h71, 8'h01);
        rd(8'h71, d); check("R8 write one clears flag", d, 0);
    endtask

    task automatic t_split_load();
        int c;
        wr(8'h72, 8'h80);
        wr(8'h74, 8'h00); wr(8'h73, 8'h07);
        wr(8'h74, 8'h01);
        rd_count(c); check("R3 high byte held", c, 7);
        wr(8'h73, 8'h05);
        rd_count(c); check("R3 atomic load", c, 16'h0105);
        ticks(1);
        rd_count(c); check("R4 16-bit decrement", c, 16'h0104);
    endtask

    task automatic t_zero_stop();
        int c;
        wr(8'h74, 8'h00); wr(8'h73, 8'h05);
        wr(8'h73, 8'h00);
        check("R6 stopped", running_o, 0);
        ticks(10);
        rd_count(c); check("R6 count unchanged", c, 0);
        check("R6 no flag", expired_o, 0);
    endtask

    task automatic t_minutes();
        int c, k, p, t;
        wr(8'h72, 8'h10);
        wr(8'h74, 8'h00); wr(8'h73, 8'h02);
        ticks(30);
        wr(8'h73, 8'h02);
        ticks(59);
        rd_count(c); check("R5 prescaler cleared on reload", c, 2);
        ticks(1);
        rd_count(c); check("R5 minute step", c, 1);
        ticks(59);
        check("R5 not yet expired", expired_o, 0);
        ticks(1);
        pulse_counts(k, p, t);
        check("R9 pwr pulse length", p, PULSE);
        check("R9 kbd not selected", k, 0);
        check("R5 minutes expiry", expired_o, 1);
        wr(8'h71, 8'h01);
    endtask

    task automatic t_kbd_gate_tmo();
        int k, p, t;
        kbd_rst_en = 1'b0;
        wr(8'h72, 8'hE0);
        wr(8'h74, 8'h00); wr(8'h73, 8'h01);
        ticks(1);
        pulse_counts(k, p, t);
        check("R9 kbd gated by enable input", k, 0);
        check("R9 tmo pulse length", t, PULSE);
        kbd_rst_en = 1'b1;
        wr(8'h71, 8'h01);
    endtask

    task automatic t_test_mode();
        int k, p, t;
        wr(8'h72, 8'h80);
        wr(8'h74, 8'h00); wr(8'h73, 8'h01);
        ticks(1);
        pulse_counts(k, p, t);
        check("R10 no reset outputs", k + p + t, 0);
        check("R10 flag still set", expired_o, 1);
        wr(8'h71, 8'h01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_seconds_expiry();
        t_split_load();
        t_zero_stop();
        t_minutes();
        t_kbd_gate_tmo();
        t_test_mode();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule